// File: doc/BRIEF.md
# Video Line and Frame Sequencer

This block turns the system clock into scanline and frame timing for a display controller and its companion timer channels. A fixed-point phase accumulator adds one clock's worth of fractional line per cycle. Each time it passes a full line length, it emits a one-cycle horizontal tick. The line length is a constant scaled by 2^FRAC_W, so a line that is not a whole number of clocks still averages to the exact value over many lines.

Ticks advance a line counter that wraps at the frame total of the selected video standard (NTSC or PAL). At a fixed blanking line the block raises vertical blank and a one-cycle blanking interrupt. The frame wrap ends blanking and emits a frame-start pulse, which the timer channels use as their unblank/sync reset. The wrap also advances a frame counter and, when interlacing is fully enabled, updates a field bit.

The standard select is sampled only during reset and at each frame wrap, so a frame never mixes line lengths or totals. All control and status pins are plain levels or single-cycle pulses. No data stream crosses the block's edge, so there is no valid/ready handshake.

Top module: `vid_frame_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `hsync_tick`, `vblank`, `vblank_irq`, `frame_start`, `field`, `line_num` and `frame_num` are all 0. The standard is taken from `pal_sel` during reset, where 0 selects NTSC and 1 selects PAL.
- R2: Count the clock edges k from the first edge after reset. A line ends on the edge where k·2^FRAC_W first reaches the running sum of line steps. The step is NTSC_STEP (default 8791293) or PAL_STEP (default 8836089), and each step must be at least 2·2^FRAC_W. `hsync_tick` is high for exactly the one cycle that follows that edge.
- R3: On every tick that does not end the frame, `line_num` increases by one. Lines run from 0 to total−1, where the total is NTSC_LINES (263) or PAL_LINES (314).
- R4: On the tick that ends line total−1, the same edge sets `line_num` to 0, increments `frame_num` and pulses `frame_start` high for one cycle.
- R5: On the tick that takes `line_num` to VBL_LINE (240), `vblank` rises and `vblank_irq` pulses high for one cycle. `vblank` then holds until the frame wrap clears it.
- R6: A change of `pal_sel` in mid-frame has no effect on the current frame's line lengths or total. The value present at the wrap edge governs the whole next frame.
- R7: At each wrap, `field` becomes bit 0 of the new `frame_num` when `ilace_en` and `ilace_alt` are both 1, and 0 otherwise. It holds between wraps.
- R8: `frame_num` counts modulo 2^FRAME_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pal_sel | input | 1 | Standard select: 0 NTSC, 1 PAL |
| ilace_en | input | 1 | Interlace enable |
| ilace_alt | input | 1 | Second interlace qualifier; field toggles only with both set |
| hsync_tick | output | 1 | One-cycle pulse at each line end |
| vblank | output | 1 | Vertical blank level |
| vblank_irq | output | 1 | One-cycle blanking interrupt |
| frame_start | output | 1 | One-cycle pulse at frame wrap (timer sync reset) |
| field | output | 1 | Interlace field bit |
| line_num | output | LINE_W | Current line index |
| frame_num | output | FRAME_W | Frame counter |

## Verification
A small configuration is used: 12 and 15 lines per frame, blanking at line 9, and steps of about 5.31 and 6.25 clocks. Its fractional parts give a mix of short and long lines, and every output is compared each cycle against an arithmetic model of the boundary sums. The bench runs stable NTSC frames with interlacing off, both interlace bits on, and only one bit on; the last of these separates the AND condition from either single bit. It also flips `pal_sel` in mid-frame and toggles it rapidly, which shows whether the standard is sampled only at the wrap, and a reset with PAL selected checks the reset-time capture. Enough frames pass to wrap the 4-bit frame counter.

// File: rtl/vts_pkg.sv
package vts_pkg;
  typedef enum logic {
    STD_NTSC = 1'b0,
    STD_PAL  = 1'b1
  } vid_std_e;
endpackage

// File: rtl/vts_line_phase.sv
module vts_line_phase
  import vts_pkg::*;
#(
  parameter int unsigned FRAC_W    = 12,
  parameter int unsigned NTSC_STEP = 8791293,
  parameter int unsigned PAL_STEP  = 8836089,
  parameter int unsigned ACC_W     = 25
) (
  input  logic     clk,
  input  logic     rst,
  input  vid_std_e std,
  output logic     line_end,
  output logic     tick
);
  localparam logic [ACC_W-1:0] ONE    = ACC_W'(1) << FRAC_W;
  localparam logic [ACC_W-1:0] STEP_N = ACC_W'(NTSC_STEP);
  localparam logic [ACC_W-1:0] STEP_P = ACC_W'(PAL_STEP);

  logic [ACC_W-1:0] phase_q;
  logic [ACC_W-1:0] phase_sum;
  logic [ACC_W-1:0] step;

  always_comb begin
    step      = (std == STD_PAL) ? STEP_P : STEP_N;
    phase_sum = phase_q + ONE;
    line_end  = (phase_sum >= step);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      tick    <= 1'b0;
    end else begin
      tick    <= line_end;
      phase_q <= line_end ? (phase_sum - step) : phase_sum;
    end
  end
endmodule

// File: rtl/vts_line_ctr.sv
module vts_line_ctr
  import vts_pkg::*;
#(
  parameter int unsigned LINE_W     = 9,
  parameter int unsigned NTSC_LINES = 263,
  parameter int unsigned PAL_LINES  = 314,
  parameter int unsigned VBL_LINE   = 240
) (
  input  logic              clk,
  input  logic              rst,
  input  vid_std_e          std,
  input  logic              line_end,
  output logic              wrap,
  output logic [LINE_W-1:0] line_q,
  output logic              vblank_q,
  output logic              vbl_irq_q,
  output logic              frame_start_q
);
  localparam logic [LINE_W-1:0] LAST_N = LINE_W'(NTSC_LINES - 1);
  localparam logic [LINE_W-1:0] LAST_P = LINE_W'(PAL_LINES - 1);
  localparam logic [LINE_W-1:0] VBL    = LINE_W'(VBL_LINE);

  logic [LINE_W-1:0] last_line;
  logic [LINE_W-1:0] line_nxt;
  logic              enter_vbl;

  always_comb begin
    last_line = (std == STD_PAL) ? LAST_P : LAST_N;
    wrap      = line_end && (line_q == last_line);
    line_nxt  = wrap ? '0 : (line_q + LINE_W'(1));
    enter_vbl = line_end && !wrap && (line_nxt == VBL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q        <= '0;
      vblank_q      <= 1'b0;
      vbl_irq_q     <= 1'b0;
      frame_start_q <= 1'b0;
    end else begin
      frame_start_q <= wrap;
      vbl_irq_q     <= enter_vbl;
      if (line_end) line_q <= line_nxt;
      if (wrap)           vblank_q <= 1'b0;
      else if (enter_vbl) vblank_q <= 1'b1;
    end
  end
endmodule

// File: rtl/vts_frame_ctr.sv
module vts_frame_ctr
  import vts_pkg::*;
#(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrap,
  input  logic               pal_sel,
  input  logic               ilace_en,
  input  logic               ilace_alt,
  output vid_std_e           std_q,
  output logic [FRAME_W-1:0] frame_q,
  output logic               field_q
);
  logic [FRAME_W-1:0] frame_nxt;
  logic               ilace_full;

  always_comb begin
    frame_nxt  = frame_q + FRAME_W'(1);
    ilace_full = ilace_en && ilace_alt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      std_q   <= vid_std_e'(pal_sel);
      frame_q <= '0;
      field_q <= 1'b0;
    end else if (wrap) begin
      std_q   <= vid_std_e'(pal_sel);
      frame_q <= frame_nxt;
      field_q <= ilace_full && frame_nxt[0];
    end
  end
endmodule

// File: rtl/vid_frame_seq.sv
module vid_frame_seq
  import vts_pkg::*;
#(
  parameter int unsigned FRAC_W     = 12,
  parameter int unsigned NTSC_STEP  = 8791293,
  parameter int unsigned PAL_STEP   = 8836089,
  parameter int unsigned NTSC_LINES = 263,
  parameter int unsigned PAL_LINES  = 314,
  parameter int unsigned VBL_LINE   = 240,
  parameter int unsigned FRAME_W    = 16,
  parameter int unsigned MAX_LINES  = (PAL_LINES > NTSC_LINES) ? PAL_LINES : NTSC_LINES,
  parameter int unsigned LINE_W     = $clog2(MAX_LINES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pal_sel,
  input  logic               ilace_en,
  input  logic               ilace_alt,
  output logic               hsync_tick,
  output logic               vblank,
  output logic               vblank_irq,
  output logic               frame_start,
  output logic               field,
  output logic [LINE_W-1:0]  line_num,
  output logic [FRAME_W-1:0] frame_num
);
  localparam int unsigned MAX_STEP = (PAL_STEP > NTSC_STEP) ? PAL_STEP : NTSC_STEP;
  localparam int unsigned ACC_W    = $clog2(MAX_STEP + 1) + 1;

  vid_std_e std;
  logic     line_end;
  logic     wrap;

  vts_line_phase #(
    .FRAC_W(FRAC_W), .NTSC_STEP(NTSC_STEP), .PAL_STEP(PAL_STEP), .ACC_W(ACC_W)
  ) u_phase (
    .clk(clk), .rst(rst), .std(std), .line_end(line_end), .tick(hsync_tick)
  );

  vts_line_ctr #(
    .LINE_W(LINE_W), .NTSC_LINES(NTSC_LINES), .PAL_LINES(PAL_LINES), .VBL_LINE(VBL_LINE)
  ) u_line (
    .clk(clk), .rst(rst), .std(std), .line_end(line_end), .wrap(wrap),
    .line_q(line_num), .vblank_q(vblank), .vbl_irq_q(vblank_irq),
    .frame_start_q(frame_start)
  );

  vts_frame_ctr #(
    .FRAME_W(FRAME_W)
  ) u_frame (
    .clk(clk), .rst(rst), .wrap(wrap), .pal_sel(pal_sel), .ilace_en(ilace_en),
    .ilace_alt(ilace_alt), .std_q(std), .frame_q(frame_num), .field_q(field)
  );
endmodule

// File: rtl/vid_frame_seq_chk.sv
module vid_frame_seq_chk #(
  parameter int unsigned LINE_W   = 9,
  parameter int unsigned FRAME_W  = 16,
  parameter int unsigned VBL_LINE = 240
) (
  input logic               clk,
  input logic               rst,
  input logic               ilace_en,
  input logic               ilace_alt,
  input logic               hsync_tick,
  input logic               vblank,
  input logic               vblank_irq,
  input logic               frame_start,
  input logic               field,
  input logic [LINE_W-1:0]  line_num,
  input logic [FRAME_W-1:0] frame_num
);
  p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
    hsync_tick |=> !hsync_tick);

  p_line_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !hsync_tick |-> $stable(line_num));

  p_line_step_r3: assert property (@(posedge clk) disable iff (rst)
    (hsync_tick && !frame_start) |-> (line_num == $past(line_num) + LINE_W'(1)));

  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (hsync_tick && line_num == '0));

  p_frame_inc_r4: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (frame_num == $past(frame_num) + FRAME_W'(1)));

  p_irq_at_vbl_r5: assert property (@(posedge clk) disable iff (rst)
    vblank_irq |-> (vblank && hsync_tick && line_num == LINE_W'(VBL_LINE)));

  p_vbl_rise_irq_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(vblank) |-> vblank_irq);

  p_vbl_clear_r5: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> !vblank);

  p_field_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !frame_start |-> $stable(field));

  p_field_off_r7: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !$past(ilace_en && ilace_alt)) |-> !field);
endmodule

bind vid_frame_seq vid_frame_seq_chk #(
  .LINE_W(LINE_W), .FRAME_W(FRAME_W), .VBL_LINE(VBL_LINE)
) u_chk (
  .clk(clk), .rst(rst), .ilace_en(ilace_en), .ilace_alt(ilace_alt),
  .hsync_tick(hsync_tick), .vblank(vblank), .vblank_irq(vblank_irq),
  .frame_start(frame_start), .field(field), .line_num(line_num),
  .frame_num(frame_num)
);

// File: tb/test_vid_frame_seq.sv
`timescale 1ns/1ps
module test_vid_frame_seq;
  localparam int FRAC   = 12;
  localparam int ONE    = 1 << FRAC;
  localparam int STEP_N = 5 * ONE + 1277;
  localparam int STEP_P = 6 * ONE + 1017;
  localparam int LN_N   = 12;
  localparam int LN_P   = 15;
  localparam int VBL    = 9;
  localparam int FW     = 4;
  localparam int LW     = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pal_sel = 1'b0;
  logic ilace_en = 1'b0;
  logic ilace_alt = 1'b0;
  logic hsync_tick, vblank, vblank_irq, frame_start, field;
  logic [LW-1:0] line_num;
  logic [FW-1:0] frame_num;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vid_frame_seq #(
    .FRAC_W(FRAC), .NTSC_STEP(STEP_N), .PAL_STEP(STEP_P),
    .NTSC_LINES(LN_N), .PAL_LINES(LN_P), .VBL_LINE(VBL), .FRAME_W(FW)
  ) i_vid_frame_seq (
    .clk(clk), .rst(rst), .pal_sel(pal_sel), .ilace_en(ilace_en),
    .ilace_alt(ilace_alt), .hsync_tick(hsync_tick), .vblank(vblank),
    .vblank_irq(vblank_irq), .frame_start(frame_start), .field(field),
    .line_num(line_num), .frame_num(frame_num)
  );

  // model state
  longint m_acc, m_bound;
  int m_line, m_frame;
  bit m_pal, m_vbl, m_irq, m_tick, m_fs, m_field;

  function automatic longint stp(bit p);
    return p ? longint'(STEP_P) : longint'(STEP_N);
  endfunction
  function automatic int tot(bit p);
    return p ? LN_P : LN_N;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    check(hsync_tick == m_tick, "R2 hsync_tick", hsync_tick, m_tick);
    check(line_num == m_line[LW-1:0], "R3 line_num", line_num, m_line);
    check(frame_start == m_fs, "R4 frame_start", frame_start, m_fs);
    check(frame_num == m_frame[FW-1:0], "R8 frame_num", frame_num, m_frame);
    check(vblank == m_vbl, "R5 vblank", vblank, m_vbl);
    check(vblank_irq == m_irq, "R5 vblank_irq", vblank_irq, m_irq);
    check(field == m_field, "R7 field", field, m_field);
  endtask

  task automatic model_edge();
    m_tick = 0; m_irq = 0; m_fs = 0;
    m_acc += ONE;
    if (m_acc >= m_bound) begin
      m_tick = 1;
      if (m_line == tot(m_pal) - 1) begin
        m_line  = 0;
        m_frame = (m_frame + 1) % (1 << FW);
        m_fs    = 1;
        m_vbl   = 0;
        m_pal   = pal_sel;                      // R6 sampled at wrap only
        m_field = (ilace_en && ilace_alt) ? m_frame[0] : 1'b0;
      end else begin
        m_line++;
        if (m_line == VBL) begin m_vbl = 1; m_irq = 1; end
      end
      m_bound += stp(m_pal);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic do_reset(input bit p);
    @(negedge clk);
    rst = 1'b1; pal_sel = p;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs cleared during reset
    check(!hsync_tick && !vblank && !vblank_irq && !frame_start && !field,
          "R1 reset flags", {hsync_tick, vblank, vblank_irq, frame_start, field}, 0);
    check(line_num == '0 && frame_num == '0, "R1 reset counters",
          {line_num, frame_num}, 0);
    m_acc = 0; m_pal = p; m_bound = stp(p);
    m_line = 0; m_frame = 0; m_vbl = 0; m_irq = 0; m_tick = 0; m_fs = 0; m_field = 0;
    rst = 1'b0;
  endtask

  initial begin
    do_reset(1'b0);
    run(1);                         // R1 first cycle after reset
    run(400);                       // NTSC, interlace off
    ilace_en = 1; ilace_alt = 1;
    run(400);                       // R7 both bits set
    ilace_alt = 0;
    run(200);                       // R7 only one bit
    ilace_alt = 1;
    run(30);
    pal_sel = 1;                    // R6 mid-frame switch
    run(800);
    run(25);
    pal_sel = 0;
    run(1300);                      // R8 frame counter wrap
    do_reset(1'b1);                 // R1 PAL captured in reset
    for (int j = 0; j < 60; j++) begin
      run(7);
      pal_sel = ~pal_sel;           // R6 rapid toggling
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule